// File: doc/BRIEF.md
# Pulse-Width Serial Command Transmitter

This block sends one command byte to a game-pad controller over a single shared data wire. The wire is open-drain. The block pulls it low through an output-enable. To show a high level it lets go of the wire and an external pull-up raises it. Each bit on the wire is made of three equal sub-bit slots: the wire is low for the first slot, carries the data value for the second, and is high for the third. After the eight command bits the block adds a ninth bit whose value is always one. That bit marks the end of the frame.

A host places a command code on `cmd` and pulses `start` for one clock. Common codes are 8'h00 (status), 8'h01 (read buttons) and 8'hFF (controller reset). The block then counts system clocks to form each slot. The default is 27 cycles per slot, which gives 1 us at 27 MHz. When the frame is finished the block releases the wire and pulses `done` for one cycle, so that a receiver can start listening for the reply.

Top module: `pw_cmd_tx`

## Requirements
- R1: Out of reset, and whenever no frame is being sent, `line_oe`, `busy` and `done` are all low, so the wire is released.
- R2: Every bit lasts three slots of SLOT_CYCLES clocks each. In the first slot `line_oe` is 1, which drives the wire low.
- R3: In the second slot of a bit, `line_oe` is the inverse of that bit's value: 1 drives a 0, and 0 releases the wire for a 1.
- R4: In the third slot of a bit, `line_oe` is 0, so the wire is released high.
- R5: A frame has CMD_W+1 bits. The command bits go out most significant first, and the stop bit, value 1, comes last. Command 8'h01 therefore goes out as 000000011.
- R6: A `start` pulse seen in idle at clock edge k raises `busy` in the cycle after edge k. That cycle is also the first cycle of the first slot. `busy` stays high for exactly (CMD_W+1)*3*SLOT_CYCLES cycles.
- R7: In the cycle right after the last slot, `done` is 1 for that one cycle only. In that cycle `busy` is 0 and `line_oe` is 0.
- R8: A `start` pulse while `busy` is high has no effect. The frame in progress keeps its bits and its timing, and it ends with only one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to send `cmd` |
| cmd | input | CMD_W | Command code, sampled on the start cycle |
| line_oe | output | 1 | 1 pulls the data wire low; 0 releases it |
| busy | output | 1 | High while a frame is on the wire |
| done | output | 1 | One-cycle pulse after the stop bit |

## Verification
The bench first sends every defined command code: 8'hFF, 8'h00 to 8'h05. These codes contain runs of ones, runs of zeros and a single set low bit, so they show whether the bit order is MSB first and whether the stop bit is added. Codes drawn at random from a fixed seed then exercise arbitrary bit patterns. The bench compares the line every cycle and keeps the mismatches for each slot kind apart. An error in the leading slot, the data slot or the trailing slot is therefore reported against its own requirement. One frame receives a second `start` carrying a different code in the middle of the frame. This separates a design that ignores the request from one that reloads its shift register or restarts its timing.

// File: rtl/pw_tx_pkg.sv
// Package: shared types for the pulse-width command transmitter.
// Assumes: slot order inside a bit is lead, data, tail.
package pw_tx_pkg;
    typedef enum logic [1:0] {
        SLOT_LEAD = 2'd0,
        SLOT_DATA = 2'd1,
        SLOT_TAIL = 2'd2
    } slot_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/pw_slot_timer.sv
// Module: pw_slot_timer
// Counts clocks while enabled and emits a one-cycle tick on the last
// cycle of each slot. Assumes SLOT_CYCLES >= 2. It restarts at zero
// whenever it is disabled.
module pw_slot_timer #(
    parameter int SLOT_CYCLES = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Slot cycle counter: wraps at the end of each slot, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/pw_frame_shifter.sv
// Module: pw_frame_shifter
// Holds the frame (command plus the appended stop bit) and shifts it left
// one place on each bit advance, so the bit being sent is always the MSB.
// Assumes load and advance never occur in the same cycle.
module pw_frame_shifter #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [CMD_W-1:0] cmd,
    output logic             cur_bit
);
    localparam int FW = CMD_W + 1;

    logic [FW-1:0] frame_q;

    // Frame register: load the command with its stop marker, then shift MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= {cmd, 1'b1};
        end else if (advance) begin
            frame_q <= {frame_q[FW-2:0], 1'b0};
        end
    end

    assign cur_bit = frame_q[FW-1];
endmodule

// File: rtl/pw_slot_encoder.sv
// Module: pw_slot_encoder
// Maps the current slot and data bit to the open-drain enable.
// The wire is low in the lead slot, equals the data in the data slot,
// and is high in the tail slot. High means released, never driven.
module pw_slot_encoder
    import pw_tx_pkg::*;
(
    input  slot_e slot,
    input  logic  active,
    input  logic  data_bit,
    output logic  line_oe
);
    logic level;

    // Wire level for the current slot.
    always_comb begin
        case (slot)
            SLOT_LEAD: level = 1'b0;
            SLOT_DATA: level = data_bit;
            default:   level = 1'b1;
        endcase
    end

    assign line_oe = active && !level;
endmodule

// File: rtl/pw_cmd_tx.sv
// Module: pw_cmd_tx (top)
// Sends one CMD_W-bit command followed by a stop bit of 1 over an
// open-drain wire. Each bit is three slots of SLOT_CYCLES clocks.
// A start request while busy is ignored. A one-cycle done pulse follows
// the last slot. Assumes an external pull-up on the wire.
module pw_cmd_tx
    import pw_tx_pkg::*;
#(
    parameter int CMD_W       = 8,
    parameter int SLOT_CYCLES = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    output logic             line_oe,
    output logic             busy,
    output logic             done
);
    localparam int FRAME_BITS = CMD_W + 1;
    localparam int BW         = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    tx_state_e     state;
    slot_e         slot;
    logic [BW-1:0] bit_idx;
    logic          tick;
    logic          load;
    logic          advance;
    logic          cur_bit;

    assign busy    = (state == ST_SEND);
    assign load    = (state == ST_IDLE) && start;
    assign advance = tick && (slot == SLOT_TAIL);

    // Sequencer: step the slots inside a bit and the bits inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            slot    <= SLOT_LEAD;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_SEND;
                        slot    <= SLOT_LEAD;
                        bit_idx <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        case (slot)
                            SLOT_LEAD: slot <= SLOT_DATA;
                            SLOT_DATA: slot <= SLOT_TAIL;
                            default: begin
                                slot <= SLOT_LEAD;
                                if (bit_idx == LAST_BIT) begin
                                    state <= ST_IDLE;
                                    done  <= 1'b1;
                                end else begin
                                    bit_idx <= bit_idx + 1'b1;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    pw_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .tick (tick)
    );

    pw_frame_shifter #(.CMD_W(CMD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .advance(advance),
        .cmd    (cmd),
        .cur_bit(cur_bit)
    );

    pw_slot_encoder u_enc (
        .slot    (slot),
        .active  (busy),
        .data_bit(cur_bit),
        .line_oe (line_oe)
    );
endmodule

// File: rtl/pw_cmd_tx_checker.sv
// Module: pw_cmd_tx_checker
// Port-level protocol assertions for pw_cmd_tx, attached by bind.
module pw_cmd_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic line_oe,
    input logic busy,
    input logic done
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe); // R1

    AST_FIRST_SLOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> line_oe); // R2

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7

    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> !done); // R8
endmodule

bind pw_cmd_tx pw_cmd_tx_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .line_oe(line_oe),
    .busy   (busy),
    .done   (done)
);

// File: tb/pw_cmd_tx_tb.sv
// Bench for pw_cmd_tx: directed command codes plus seeded random codes,
// with per-cycle comparison against a reference waveform function.
module pw_cmd_tx_tb;
    localparam int CMD_W       = 8;
    localparam int SLOT_CYCLES = 27;
    localparam int BIT_CYC     = 3 * SLOT_CYCLES;
    localparam int FRAME_CYC   = (CMD_W + 1) * BIT_CYC;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CMD_W-1:0] cmd = '0;
    logic             line_oe;
    logic             busy;
    logic             done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pw_cmd_tx #(.CMD_W(CMD_W), .SLOT_CYCLES(SLOT_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .line_oe(line_oe), .busy(busy), .done(done)
    );

    // Expected enable at frame cycle offset off (1 = first cycle of the frame).
    function automatic logic exp_oe(input logic [CMD_W-1:0] c, input int off);
        logic [CMD_W:0] fr;
        int b;
        int s;
        fr = {c, 1'b1};
        b = (off - 1) / BIT_CYC;
        s = ((off - 1) % BIT_CYC) / SLOT_CYCLES;
        if (s == 0) return 1'b1;
        if (s == 1) return !fr[CMD_W - b];
        return 1'b0;
    endfunction

    function automatic int slot_of(input int off);
        return ((off - 1) % BIT_CYC) / SLOT_CYCLES;
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Send one frame; if inject, pulse start with another code mid-frame.
    task automatic send_frame(input logic [CMD_W-1:0] c, input bit inject);
        int bad_lead = 0;
        int bad_data = 0;
        int bad_tail = 0;
        int bad_busy = 0;
        int done_seen = 0;
        @(negedge clk);
        cmd = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd = ~c;
        for (int i = 1; i <= FRAME_CYC; i++) begin
            if (i > 1) @(negedge clk);
            start = 1'b0;
            if (line_oe !== exp_oe(c, i)) begin
                if (slot_of(i) == 0) bad_lead++;
                else if (slot_of(i) == 1) bad_data++;
                else bad_tail++;
            end
            if (busy !== 1'b1) bad_busy++;
            if (done === 1'b1) done_seen++;
            if (inject && (i == FRAME_CYC / 2)) begin
                cmd = c ^ 8'hA5;
                start = 1'b1;
            end
        end
        @(negedge clk);
        start = 1'b0;
        check("R2 lead-slot mismatches", bad_lead, 0);
        check("R3 data-slot mismatches", bad_data, 0);
        check("R4 tail-slot mismatches", bad_tail, 0);
        check("R6 busy low inside frame", bad_busy, 0);
        check("R7 done high", int'(done), 1);
        check("R7 busy low at done", int'(busy), 0);
        check("R7 line released at done", int'(line_oe), 0);
        if (inject) check("R8 early done after ignored start", done_seen, 0);
        @(negedge clk);
        check("R7 done lasts one cycle", int'(done), 0);
        if (inject) check("R8 no restart after ignored start", int'(busy), 0);
        repeat (3) @(negedge clk);
        check("R1 idle released", int'(line_oe), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            summary();
        end
    end

    initial begin
        logic [CMD_W-1:0] codes [7];
        int seed_dummy;
        codes = '{8'hFF, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        check("R1 reset line_oe", int'(line_oe), 0);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(busy), 0);
        // R5: defined codes, including 8'h01 -> 000000011 on the wire
        foreach (codes[k]) send_frame(codes[k], 1'b0);
        // R8: second start mid-frame with a different code
        send_frame(8'h3C, 1'b1);
        for (int n = 0; n < 6; n++) send_frame(CMD_W'($urandom), 1'b0);
        summary();
    end
endmodule